// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the processor-side engine that runs one bus transaction at a time on a bus whose low data pins also carry the low address bits. An internal requester asks for a memory or I/O transfer. The request gives the direction, the width (byte or word), a 20-bit address and the write data. The sequencer walks the transfer through four clock states. In the first state it puts out the address and a latch strobe, so that external logic can hold the address. In the later states it moves data, and it stretches the transfer while the addressed device reports that it is not ready.

The sequencer also gives up the whole bus to another master on request. While a hold request is high, it finishes any transfer already running, floats every bus output and raises an acknowledge. It takes the bus back once the request drops. A word request at an odd address is refused with an error pulse and never reaches the bus. Tri-state pins are modelled as a value port plus an output-enable port, so the block can be integrated with any pad ring.

Top module: `muxbus_sequencer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, pin_hlda, pin_ale, pin_ad_oe, pin_ahi_oe, pin_ctl_oe and done are 0, and pin_rd_n, pin_wr_n and pin_den_n are 1.
- R2: An idle, unheld sequencer raises req_ack in the same cycle as an aligned req_valid. The following cycle is the address state, and it lasts exactly one cycle. In it, pin_ale=1, pin_ad_oe=1, pin_ad_out=address[15:0], pin_ahi_oe=1 and pin_ctl_oe=1. For memory, pin_ahi_out=address[19:16]; for I/O it is 0. pin_rd_n and pin_wr_n are both 1.
- R3: pin_mio is 1 for memory and 0 for I/O. It holds that value from the address state to the final state.
- R4: A read drives pin_rd_n low in the second state and in every third-state cycle, including waits, and high in the final state. pin_ad_oe is 0 after the address state, and pin_dtr is 0. pin_ad_in is captured at the clock edge that ends the last third-state cycle and appears on rdata while done=1.
- R5: A write drives pin_ad_out=write data with pin_ad_oe=1 from the second state to the final state. pin_wr_n is low in the second and third states and high in the final state. pin_dtr is 1.
- R6: pin_ready is sampled at the edge ending the second state and at the edge ending each third-state cycle while it has been seen low. The third state repeats once per leading low sample. done is 1 only in the final state: 3+W cycles after the address state, where W is the number of leading low samples.
- R7: pin_den_n is 1 in the address state and 0 from the second state to the final state.
- R8: pin_bhe_n is 0 in the address state for a word access or a byte access at an odd address. It is 1 for an even-address byte, and 1 in every state other than the address state.
- R9: With pin_hold high, the running transfer completes. In the next cycle pin_hlda=1 and pin_ad_oe, pin_ahi_oe and pin_ctl_oe are 0. No request is acknowledged while the hold lasts. One cycle after pin_hold drops, pin_hlda is 0 and requests are accepted again.
- R10: A word request at an odd address gives align_err=1 and req_ack=1 in the same cycle. No address state follows: pin_ale and pin_ctl_oe stay 0.
- R11: Between transfers the sequencer is idle: every output enable is 0 and all strobes are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_mem | input | 1 | 1 memory, 0 I/O |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word, 0 byte |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | Request consumed this cycle |
| done | output | 1 | Final state of a transfer |
| rdata | output | 16 | Captured read data |
| align_err | output | 1 | Odd-address word request refused |
| pin_ad_out | output | 16 | Shared address/data pin value |
| pin_ad_oe | output | 1 | Shared pin output enable |
| pin_ad_in | input | 16 | Shared pin input value |
| pin_ahi_out | output | 4 | Upper address / status pin value |
| pin_ahi_oe | output | 1 | Upper pin output enable |
| pin_ale | output | 1 | Address latch strobe |
| pin_mio | output | 1 | Memory (1) or I/O (0) |
| pin_rd_n | output | 1 | Read strobe, active low |
| pin_wr_n | output | 1 | Write strobe, active low |
| pin_bhe_n | output | 1 | Upper byte lane enable, active low |
| pin_dtr | output | 1 | Buffer direction, 1 transmit |
| pin_den_n | output | 1 | Buffer enable, active low |
| pin_ctl_oe | output | 1 | Output enable for control pins |
| pin_ready | input | 1 | Device ready |
| pin_hold | input | 1 | Bus release request |
| pin_hlda | output | 1 | Bus release acknowledge |

## Verification
A wrong phase register shows on the pins within one cycle. A second ALE cycle, a strobe missing in a wait state, or done arriving early or late changes the cycle count between ALE and done, and the bench compares that count with the wait pattern it drives. A stale latched request field shows up in the next address or data state as a wrong address, data, byte-lane or memory/I/O value. A wrong ready sample moves done by one cycle or more. A hold handled in the wrong state shows as enables that stay on, or as an acknowledge that arrives or clears one cycle late.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4,
        PH_HOLD = 3'd5
    } phase_e;
endpackage

// File: rtl/muxbus_lane.sv
module muxbus_lane (
    input  logic word,
    input  logic a0,
    output logic bhe_n
);
    // upper lane joins for any word or for an odd byte
    always_comb begin
        bhe_n = !(word || a0);
    end
endmodule

// File: rtl/muxbus_pins.sv
module muxbus_pins
    import muxbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16,
    localparam int HW = AW - DW
) (
    input  phase_e          ph,
    input  logic            mem,
    input  logic            write,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            bhe_n_t1,
    output logic [DW-1:0]   ad_out,
    output logic            ad_oe,
    output logic [HW-1:0]   ahi_out,
    output logic            ahi_oe,
    output logic            ale,
    output logic            mio,
    output logic            rd_n,
    output logic            wr_n,
    output logic            bhe_n,
    output logic            dtr,
    output logic            den_n,
    output logic            ctl_oe,
    output logic            hlda
);
    logic data_ph;
    logic own_ph;

    always_comb begin
        data_ph = (ph == PH_T2) || (ph == PH_T3) || (ph == PH_T4);
        own_ph  = (ph == PH_T1) || data_ph;

        ad_out  = '0;
        ad_oe   = 1'b0;
        ahi_out = '0;
        ahi_oe  = own_ph;
        ale     = (ph == PH_T1);
        mio     = own_ph && mem;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        bhe_n   = 1'b1;
        dtr     = own_ph && write;
        den_n   = !data_ph;
        ctl_oe  = own_ph;
        hlda    = (ph == PH_HOLD);

        if (ph == PH_T1) begin
            ad_out  = addr[DW-1:0];
            ad_oe   = 1'b1;
            ahi_out = mem ? addr[AW-1:DW] : '0;
            bhe_n   = bhe_n_t1;
        end
        if (data_ph) begin
            ad_oe = write;
            if (write) begin
                ad_out = wdata;
            end
            if (ph != PH_T4) begin
                rd_n = write;
                wr_n = !write;
            end
        end
    end
endmodule

// File: rtl/muxbus_sequencer.sv
module muxbus_sequencer
    import muxbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16,
    localparam int HW = AW - DW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_mem,
    input  logic            req_write,
    input  logic            req_word,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            req_ack,
    output logic            done,
    output logic [DW-1:0]   rdata,
    output logic            align_err,
    output logic [DW-1:0]   pin_ad_out,
    output logic            pin_ad_oe,
    input  logic [DW-1:0]   pin_ad_in,
    output logic [HW-1:0]   pin_ahi_out,
    output logic            pin_ahi_oe,
    output logic            pin_ale,
    output logic            pin_mio,
    output logic            pin_rd_n,
    output logic            pin_wr_n,
    output logic            pin_bhe_n,
    output logic            pin_dtr,
    output logic            pin_den_n,
    output logic            pin_ctl_oe,
    input  logic            pin_ready,
    input  logic            pin_hold,
    output logic            pin_hlda
);
    typedef struct packed {
        phase_e          ph;
        logic            mem;
        logic            write;
        logic            word;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
        logic [DW-1:0]   rdata;
        logic            rdy;
    } seq_t;

    seq_t st_d, st_q;
    logic idle_open;
    logic misaligned;
    logic bhe_n_lat;

    always_comb begin
        idle_open  = (st_q.ph == PH_IDLE) && !pin_hold;
        misaligned = req_word && req_addr[0];
        req_ack    = idle_open && req_valid;
        align_err  = req_ack && misaligned;
        done       = (st_q.ph == PH_T4);
        rdata      = st_q.rdata;
    end

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (pin_hold) begin
                    st_d.ph = PH_HOLD;
                end else if (req_valid && !misaligned) begin
                    st_d.ph    = PH_T1;
                    st_d.mem   = req_mem;
                    st_d.write = req_write;
                    st_d.word  = req_word;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                end
            end
            PH_T1: st_d.ph = PH_T2;
            PH_T2: begin
                st_d.ph  = PH_T3;
                st_d.rdy = pin_ready;
            end
            PH_T3: begin
                if (st_q.rdy) begin
                    st_d.ph = PH_T4;
                    if (!st_q.write) begin
                        st_d.rdata = pin_ad_in;
                    end
                end else begin
                    st_d.rdy = pin_ready;
                end
            end
            PH_T4: st_d.ph = pin_hold ? PH_HOLD : PH_IDLE;
            PH_HOLD: begin
                if (!pin_hold) begin
                    st_d.ph = PH_IDLE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    muxbus_lane u_lane (
        .word  (st_q.word),
        .a0    (st_q.addr[0]),
        .bhe_n (bhe_n_lat)
    );

    muxbus_pins #(.AW(AW), .DW(DW)) u_pins (
        .ph       (st_q.ph),
        .mem      (st_q.mem),
        .write    (st_q.write),
        .addr     (st_q.addr),
        .wdata    (st_q.wdata),
        .bhe_n_t1 (bhe_n_lat),
        .ad_out   (pin_ad_out),
        .ad_oe    (pin_ad_oe),
        .ahi_out  (pin_ahi_out),
        .ahi_oe   (pin_ahi_oe),
        .ale      (pin_ale),
        .mio      (pin_mio),
        .rd_n     (pin_rd_n),
        .wr_n     (pin_wr_n),
        .bhe_n    (pin_bhe_n),
        .dtr      (pin_dtr),
        .den_n    (pin_den_n),
        .ctl_oe   (pin_ctl_oe),
        .hlda     (pin_hlda)
    );

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !(!pin_rd_n && !pin_wr_n));
    assert_ale_single_R2: assert property (@(posedge clk) disable iff (rst)
        pin_ale |=> !pin_ale);
    assert_mio_held_R3: assert property (@(posedge clk) disable iff (rst)
        (pin_ctl_oe && !pin_ale) |-> $stable(pin_mio));
    assert_wait_repeats_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph == PH_T3 && !st_q.rdy) |=> (st_q.ph == PH_T3));
    assert_den_off_in_addr_R7: assert property (@(posedge clk) disable iff (rst)
        pin_ale |-> pin_den_n);
    assert_float_on_hlda_R9: assert property (@(posedge clk) disable iff (rst)
        pin_hlda |-> (!pin_ad_oe && !pin_ahi_oe && !pin_ctl_oe));
    assert_no_ack_held_R9: assert property (@(posedge clk) disable iff (rst)
        pin_hlda |-> !req_ack);
    assert_err_no_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        align_err |=> !pin_ale);
endmodule

// File: tb/tb_muxbus_sequencer.sv
module tb_muxbus_sequencer;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_mem = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic req_ack, done, align_err;
    logic [15:0] rdata, pin_ad_out;
    logic [15:0] pin_ad_in = '0;
    logic pin_ad_oe, pin_ahi_oe, pin_ale, pin_mio, pin_rd_n, pin_wr_n;
    logic pin_bhe_n, pin_dtr, pin_den_n, pin_ctl_oe, pin_hlda;
    logic [3:0] pin_ahi_out;
    logic pin_ready = 1'b1, pin_hold = 1'b0;
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    muxbus_sequencer dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mem(req_mem),
        .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ack(req_ack), .done(done), .rdata(rdata),
        .align_err(align_err), .pin_ad_out(pin_ad_out), .pin_ad_oe(pin_ad_oe),
        .pin_ad_in(pin_ad_in), .pin_ahi_out(pin_ahi_out), .pin_ahi_oe(pin_ahi_oe),
        .pin_ale(pin_ale), .pin_mio(pin_mio), .pin_rd_n(pin_rd_n),
        .pin_wr_n(pin_wr_n), .pin_bhe_n(pin_bhe_n), .pin_dtr(pin_dtr),
        .pin_den_n(pin_den_n), .pin_ctl_oe(pin_ctl_oe), .pin_ready(pin_ready),
        .pin_hold(pin_hold), .pin_hlda(pin_hlda)
    );

    function automatic logic exp_bhe_n(input logic word, input logic a0);
        return !(word || a0);
    endfunction

    function automatic logic [3:0] exp_ahi(input logic mem, input logic [19:0] a);
        return mem ? a[19:16] : 4'h0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_idle_float(input string tag);
        chk(!pin_ad_oe && !pin_ahi_oe && !pin_ctl_oe, tag,
            {pin_ad_oe, pin_ahi_oe, pin_ctl_oe}, 0);
        chk(pin_rd_n && pin_wr_n && pin_den_n && !pin_ale, tag,
            {pin_rd_n, pin_wr_n, pin_den_n, pin_ale}, 4'b1110);
    endtask

    task automatic run_cycle(input bit mem, input bit wr, input bit word,
                             input logic [19:0] addr, input logic [15:0] wd,
                             input logic [15:0] rd, input int waits,
                             input bit hold_mid);
        int last;
        req_mem = mem; req_write = wr; req_word = word;
        req_addr = addr; req_wdata = wd; req_valid = 1'b1;
        #1;
        chk(req_ack && !align_err, "R2 ack", {req_ack, align_err}, 2'b10);
        @(negedge clk);
        req_valid = 1'b0;
        pin_ad_in = rd;
        chk(pin_ale && pin_ad_oe && pin_ahi_oe && pin_ctl_oe, "R2 t1 enables",
            {pin_ale, pin_ad_oe, pin_ahi_oe, pin_ctl_oe}, 4'hf);
        chk(pin_ad_out == addr[15:0], "R2 t1 low addr", pin_ad_out, addr[15:0]);
        chk(pin_ahi_out == exp_ahi(mem, addr), "R2 t1 high addr",
            pin_ahi_out, exp_ahi(mem, addr));
        chk(pin_rd_n && pin_wr_n, "R2 t1 strobes", {pin_rd_n, pin_wr_n}, 2'b11);
        chk(pin_mio == mem, "R3 t1 mio", pin_mio, mem);
        chk(pin_bhe_n == exp_bhe_n(word, addr[0]), "R8 t1 bhe",
            pin_bhe_n, exp_bhe_n(word, addr[0]));
        chk(pin_den_n == 1'b1, "R7 t1 den", pin_den_n, 1);
        last = 3 + waits;
        for (int k = 1; k < last; k++) begin
            @(negedge clk);
            pin_ready = (k >= waits + 1);
            if (hold_mid && k == 1) pin_hold = 1'b1;
            chk(!pin_ale && !done, "R6 mid state", {pin_ale, done}, 0);
            chk(pin_den_n == 1'b0, "R7 data den", pin_den_n, 0);
            chk(pin_mio == mem, "R3 data mio", pin_mio, mem);
            chk(pin_bhe_n == 1'b1, "R8 data bhe", pin_bhe_n, 1);
            if (wr) begin
                chk(!pin_wr_n && pin_rd_n && pin_dtr && pin_ad_oe, "R5 strobe",
                    {pin_wr_n, pin_rd_n, pin_dtr, pin_ad_oe}, 4'b0111);
                chk(pin_ad_out == wd, "R5 data", pin_ad_out, wd);
            end else begin
                chk(!pin_rd_n && pin_wr_n && !pin_dtr && !pin_ad_oe, "R4 strobe",
                    {pin_rd_n, pin_wr_n, pin_dtr, pin_ad_oe}, 4'b0100);
            end
        end
        @(negedge clk);
        pin_ready = 1'b1;
        chk(done == 1'b1, "R6 done timing", done, 1);
        chk(pin_rd_n && pin_wr_n && !pin_den_n, "R4 t4 strobes",
            {pin_rd_n, pin_wr_n, pin_den_n}, 3'b110);
        chk(pin_mio == mem, "R3 t4 mio", pin_mio, mem);
        if (wr) chk(pin_ad_oe && pin_ad_out == wd, "R5 t4 data", pin_ad_out, wd);
        else chk(rdata == rd, "R4 rdata", rdata, rd);
        @(negedge clk);
        chk(!done, "R6 single done", done, 0);
        if (hold_mid) begin
            chk(pin_hlda == 1'b1, "R9 hlda after cycle", pin_hlda, 1);
            chk_idle_float("R9 floated");
            req_valid = 1'b1;
            #1;
            chk(!req_ack, "R9 no ack while held", req_ack, 0);
            req_valid = 1'b0;
            pin_hold = 1'b0;
            @(negedge clk);
            chk(!pin_hlda, "R9 hlda released", pin_hlda, 1'b0);
        end else begin
            chk_idle_float("R11 idle");
        end
    endtask

    task automatic run_misaligned(input logic [19:0] addr);
        req_mem = 1'b1; req_write = 1'b0; req_word = 1'b1;
        req_addr = addr | 20'h1; req_valid = 1'b1;
        #1;
        chk(align_err && req_ack, "R10 err pulse", {align_err, req_ack}, 2'b11);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!pin_ale && !pin_ctl_oe, "R10 no cycle", {pin_ale, pin_ctl_oe}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        chk(!pin_hlda && !done, "R1 in reset", {pin_hlda, done}, 0);
        chk_idle_float("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        chk_idle_float("R1 after reset");

        // directed corners
        run_cycle(1, 0, 1, 20'hAD330, 16'h0000, 16'h1234, 0, 0);
        run_cycle(1, 1, 1, 20'h47000, 16'hF3C0, 16'h0000, 0, 0);
        run_cycle(0, 0, 0, 20'hF0081, 16'h0000, 16'h00A5, 2, 0);
        run_cycle(0, 1, 0, 20'h30042, 16'h5A5A, 16'h0000, 3, 0);
        run_cycle(1, 0, 0, 20'h12345, 16'h0000, 16'hBEEF, 1, 1);
        run_misaligned(20'h0F00F);

        // hold while idle
        pin_hold = 1'b1;
        @(negedge clk);
        chk(pin_hlda, "R9 idle hold", pin_hlda, 1);
        req_valid = 1'b1; req_word = 1'b0;
        #1;
        chk(!req_ack, "R9 idle hold no ack", req_ack, 0);
        req_valid = 1'b0;
        pin_hold = 1'b0;
        @(negedge clk);
        chk(!pin_hlda, "R9 idle release", pin_hlda, 0);

        for (int i = 0; i < 60; i++) begin
            logic [19:0] a;
            bit m, w, wd;
            a  = 20'($urandom);
            m  = 1'($urandom);
            w  = 1'($urandom);
            wd = 1'($urandom);
            if (wd && a[0]) run_misaligned(a);
            else run_cycle(m, w, wd, a, 16'($urandom), 16'($urandom),
                           int'($urandom % 4), ($urandom % 8) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule